// File: doc/BRIEF.md
# Staged Byte Access Port for a Wide Down-Counter

This block sits between a narrow processor bus and a 16-bit down-counter that also carries an optional upper extension byte. Software writes the counter value one byte at a time. Each byte lands in a holding register. The whole value goes to the counter core as a single atomic load only when the high byte arrives. The extension byte is sticky: once written, it stays staged and is reused by every later low/high write pair until software writes it again. If it has never been written since reset, it is zero, so a low-then-high pair is already a complete write.

Reads follow a different fixed order. Reading the extension byte freezes the high and low bytes of the same counter cycle. Reading the high byte without that step freezes the matching low byte. The next low-byte read returns the frozen copy, so the bytes software assembles always belong to one counter value. A sticky sequence-error flag records any high-byte write that arrives with no low-byte write since the last commit. Software can read the flag, and reading it clears it.

Two small state machines track the access sequence. The write machine has three states:
- `WS_IDLE` means nothing is pending.
- `WS_EXT` means only the extension byte is staged.
- `WS_LOW` means the low byte is staged and a commit is armed.

Its transitions are named as follows:
- `idle_to_ext`: an extension write from `WS_IDLE`.
- `to_low`: a low write from any state.
- `commit`: a high write in `WS_LOW`, which returns to `WS_IDLE`.
- `orphan`: a high write in `WS_IDLE` or `WS_EXT`, which also returns to `WS_IDLE` and sets the error flag.

An extension write in `WS_LOW` leaves the machine in `WS_LOW`.

The read machine also has three states:
- `RS_IDLE` means nothing is frozen.
- `RS_LOWHELD` means the low byte is frozen.
- `RS_ALLHELD` means the high and low bytes are frozen.

Its transitions are named as follows:
- `grab_all`: an extension read from any state, which moves to `RS_ALLHELD`.
- `grab_low`: a high read, which moves to `RS_LOWHELD`. When it happens in `RS_ALLHELD` it returns the frozen high byte.
- `release`: a low read, which moves to `RS_IDLE`.

A status read leaves the read state unchanged.

Top module: `tmr_bus_access`

## Requirements
- R1: While reset is held and after it is released, `load_value` is 0, `load_strobe` is 0, `bus_rdata` is 0, the staged extension is 0, the error flag is clear and both sequences are idle.
- R2: A write to address 2 (high byte) with a write to address 1 (low byte) since the last commit raises `load_strobe` for exactly the next cycle, with `load_value` = {extension, high, low} (bits 23:16, 15:8, 7:0).
- R3: The extension byte written at address 0 is used by every later commit until it is rewritten; if it was never written since reset the extension field of a commit is 0.
- R4: Writes to address 0, address 1 or address 3 never raise `load_strobe` and never change `load_value`.
- R5: `load_value` holds its value in every cycle in which `load_strobe` is low.
- R6: A write to address 2 with no address-1 write since the last commit produces no strobe and sets the error flag; a read of address 3 returns the flag in bit 0 (bits 7:1 zero) and clears it.
- R7: A read of address 2 outside `RS_ALLHELD` returns the live high byte and freezes the live low byte of the same cycle; the next read of address 1 returns that frozen byte.
- R8: A read of address 0 returns the live extension byte and freezes the live high and low bytes; the following reads of address 2 and address 1 return the frozen bytes.
- R9: A read of address 1 with nothing frozen returns the live low byte, and any read of address 1 leaves nothing frozen.
- R10: `bus_rdata` is updated in the cycle after a read strobe and holds its value until the next read strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 2 | Byte select: 0 extension, 1 low, 2 high, 3 status |
| bus_wdata | input | 8 | Write data byte |
| bus_wr | input | 1 | Write strobe, one cycle per byte |
| bus_rd | input | 1 | Read strobe, one cycle per byte |
| bus_rdata | output | 8 | Read data, valid the cycle after the read strobe |
| cnt_live | input | 24 | Live counter value {extension, high, low} |
| load_value | output | 24 | Committed value toward the counter core |
| load_strobe | output | 1 | One-cycle pulse when `load_value` is newly committed |

## Verification
The bound checker watches on every cycle that a strobe follows only a high-byte write and carries that write's byte in its high field. It also checks that the committed value never moves between strobes, that the error flag rises only on an orphan high write, and that an extension read always leaves both bytes frozen. Whether the returned bytes really come from one counter cycle can only be seen in the bench's scenarios. The same holds for the sticky reuse of the extension across many commits and the clear-on-read of the error flag. In those scenarios a free-running counter model changes every byte on each clock, and a reference model follows every access.

// File: rtl/tmr_acc_pkg.sv
package tmr_acc_pkg;

    // Byte select decoding on the bus address
    localparam logic [1:0] ADR_EXT  = 2'd0;
    localparam logic [1:0] ADR_LO   = 2'd1;
    localparam logic [1:0] ADR_HI   = 2'd2;
    localparam logic [1:0] ADR_STAT = 2'd3;

    typedef enum logic [1:0] {
        WS_IDLE = 2'd0,
        WS_EXT  = 2'd1,
        WS_LOW  = 2'd2
    } wr_state_e;

    typedef enum logic [1:0] {
        RS_IDLE    = 2'd0,
        RS_LOWHELD = 2'd1,
        RS_ALLHELD = 2'd2
    } rd_state_e;

endpackage

// File: rtl/tmr_bus_decode.sv
module tmr_bus_decode
    import tmr_acc_pkg::*;
#(
    parameter int ADDR_W = 2
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    input  logic              rd,
    output logic [3:0]        wr_sel,
    output logic [3:0]        rd_sel
);

    // One select line per byte address
    for (genvar i = 0; i < 4; i++) begin : g_sel
        always_comb begin
            wr_sel[i] = wr && (addr == ADDR_W'(i));
            rd_sel[i] = rd && (addr == ADDR_W'(i));
        end
    end

endmodule

// File: rtl/tmr_wr_stage.sv
module tmr_wr_stage
    import tmr_acc_pkg::*;
#(
    parameter int BYTE_W = 8,
    localparam int VAL_W = 3 * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_ext,
    input  logic              wr_lo,
    input  logic              wr_hi,
    input  logic [BYTE_W-1:0] wdata,
    input  logic              clr_err,
    output logic [VAL_W-1:0]  load_value,
    output logic              load_strobe,
    output logic              seq_err,
    output wr_state_e         state
);

    wr_state_e         state_nx;
    logic [BYTE_W-1:0] ext_stage;
    logic [BYTE_W-1:0] low_stage;

    // Next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            WS_IDLE: begin
                if (wr_lo)       state_nx = WS_LOW;   // to_low
                else if (wr_ext) state_nx = WS_EXT;   // idle_to_ext
            end
            WS_EXT: begin
                if (wr_lo)       state_nx = WS_LOW;   // to_low
                else if (wr_hi)  state_nx = WS_IDLE;  // orphan
            end
            WS_LOW: begin
                if (wr_hi)       state_nx = WS_IDLE;  // commit
            end
            default:             state_nx = WS_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= WS_IDLE;
        else        state <= state_nx;
    end

    // Staging, commit and error outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ext_stage   <= '0;
            low_stage   <= '0;
            load_value  <= '0;
            load_strobe <= 1'b0;
            seq_err     <= 1'b0;
        end else begin
            load_strobe <= 1'b0;
            if (wr_ext) ext_stage <= wdata;
            if (wr_lo)  low_stage <= wdata;
            if (wr_hi) begin
                if (state == WS_LOW) begin
                    load_value  <= {ext_stage, wdata, low_stage};
                    load_strobe <= 1'b1;
                end else begin
                    seq_err <= 1'b1;
                end
            end else if (clr_err) begin
                seq_err <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/tmr_rd_snap.sv
module tmr_rd_snap
    import tmr_acc_pkg::*;
#(
    parameter int BYTE_W = 8,
    localparam int VAL_W = 3 * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_ext,
    input  logic              rd_lo,
    input  logic              rd_hi,
    input  logic              rd_stat,
    input  logic [VAL_W-1:0]  live,
    input  logic              seq_err,
    output logic [BYTE_W-1:0] rdata,
    output rd_state_e         state
);

    rd_state_e         state_nx;
    logic [BYTE_W-1:0] live_b [3];
    logic [BYTE_W-1:0] snap_hi;
    logic [BYTE_W-1:0] snap_lo;

    // Split the live value into byte lanes: 0 low, 1 high, 2 extension
    for (genvar i = 0; i < 3; i++) begin : g_lane
        assign live_b[i] = live[i*BYTE_W +: BYTE_W];
    end

    // Next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            RS_IDLE, RS_LOWHELD, RS_ALLHELD: begin
                if (rd_ext)      state_nx = RS_ALLHELD;  // grab_all
                else if (rd_hi)  state_nx = RS_LOWHELD;  // grab_low
                else if (rd_lo)  state_nx = RS_IDLE;     // release
            end
            default:             state_nx = RS_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= RS_IDLE;
        else        state <= state_nx;
    end

    // Snapshot and read data outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            snap_hi <= '0;
            snap_lo <= '0;
            rdata   <= '0;
        end else if (rd_ext) begin
            rdata   <= live_b[2];
            snap_hi <= live_b[1];
            snap_lo <= live_b[0];
        end else if (rd_hi) begin
            if (state == RS_ALLHELD) begin
                rdata <= snap_hi;
            end else begin
                rdata   <= live_b[1];
                snap_lo <= live_b[0];
            end
        end else if (rd_lo) begin
            if (state == RS_IDLE) rdata <= live_b[0];
            else                  rdata <= snap_lo;
        end else if (rd_stat) begin
            rdata <= {{(BYTE_W-1){1'b0}}, seq_err};
        end
    end

endmodule

// File: rtl/tmr_bus_access.sv
module tmr_bus_access
    import tmr_acc_pkg::*;
#(
    parameter int BYTE_W = 8,
    parameter int ADDR_W = 2,
    localparam int VAL_W = 3 * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BYTE_W-1:0] bus_wdata,
    input  logic              bus_wr,
    input  logic              bus_rd,
    output logic [BYTE_W-1:0] bus_rdata,
    input  logic [VAL_W-1:0]  cnt_live,
    output logic [VAL_W-1:0]  load_value,
    output logic              load_strobe
);

    logic [3:0] wr_sel;
    logic [3:0] rd_sel;
    logic       seq_err;
    wr_state_e  wr_state;
    rd_state_e  rd_state;

    tmr_bus_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr   (bus_addr),
        .wr     (bus_wr),
        .rd     (bus_rd),
        .wr_sel (wr_sel),
        .rd_sel (rd_sel)
    );

    tmr_wr_stage #(.BYTE_W(BYTE_W)) u_wr (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_ext      (wr_sel[ADR_EXT]),
        .wr_lo       (wr_sel[ADR_LO]),
        .wr_hi       (wr_sel[ADR_HI]),
        .wdata       (bus_wdata),
        .clr_err     (rd_sel[ADR_STAT]),
        .load_value  (load_value),
        .load_strobe (load_strobe),
        .seq_err     (seq_err),
        .state       (wr_state)
    );

    tmr_rd_snap #(.BYTE_W(BYTE_W)) u_rd (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_ext  (rd_sel[ADR_EXT]),
        .rd_lo   (rd_sel[ADR_LO]),
        .rd_hi   (rd_sel[ADR_HI]),
        .rd_stat (rd_sel[ADR_STAT]),
        .live    (cnt_live),
        .seq_err (seq_err),
        .rdata   (bus_rdata),
        .state   (rd_state)
    );

endmodule

// File: rtl/tmr_bus_access_chk.sv
module tmr_bus_access_chk
    import tmr_acc_pkg::*;
#(
    parameter int BYTE_W = 8,
    parameter int ADDR_W = 2,
    localparam int VAL_W = 3 * BYTE_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [BYTE_W-1:0] bus_wdata,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [VAL_W-1:0]  load_value,
    input logic              load_strobe,
    input logic              seq_err,
    input wr_state_e         wr_state,
    input rd_state_e         rd_state
);

    // R2
    strobe_after_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_strobe |-> $past(bus_wr && bus_addr == ADR_HI));

    // R2
    commit_high_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_strobe |-> load_value[2*BYTE_W-1:BYTE_W] == $past(bus_wdata));

    // R4
    no_strobe_other_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr != ADR_HI) |=> !load_strobe);

    // R5
    value_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !load_strobe |-> $stable(load_value));

    // R6
    err_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(seq_err) |-> $past(bus_wr && bus_addr == ADR_HI && wr_state != WS_LOW));

    // R8
    grab_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == ADR_EXT) |=> rd_state == RS_ALLHELD);

endmodule

bind tmr_bus_access tmr_bus_access_chk #(.BYTE_W(BYTE_W), .ADDR_W(ADDR_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_addr    (bus_addr),
    .bus_wdata   (bus_wdata),
    .bus_wr      (bus_wr),
    .bus_rd      (bus_rd),
    .load_value  (load_value),
    .load_strobe (load_strobe),
    .seq_err     (seq_err),
    .wr_state    (wr_state),
    .rd_state    (rd_state)
);

// File: tb/sim_tmr_bus_access.sv
`timescale 1ns/1ps
module sim_tmr_bus_access;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [7:0]  bus_rdata;
    logic [23:0] cnt_live = 24'h5A3C1E;
    logic [23:0] load_value;
    logic        load_strobe;

    int checks = 0;
    int fails  = 0;

    // Reference model state
    logic [7:0]  m_ext = '0, m_low = '0, m_shi = '0, m_slo = '0;
    bit          m_pend = 0, m_err = 0;
    int          m_rs = 0;                 // 0 idle, 1 low held, 2 all held
    logic [23:0] m_val = '0;
    logic [7:0]  m_rdata = '0;

    always #4 clk = ~clk;                 // 125 MHz

    // Free-running counter model: every byte moves each clock
    always @(posedge clk) cnt_live <= cnt_live - 24'h010203;

    tmr_bus_access u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
        .cnt_live(cnt_live), .load_value(load_value), .load_strobe(load_strobe)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_read(input logic [1:0] a, input logic [23:0] live);
        logic [7:0] r;
        case (a)
            2'd0: begin r = live[23:16]; m_shi = live[15:8]; m_slo = live[7:0]; m_rs = 2; end
            2'd2: begin
                if (m_rs == 2) r = m_shi;
                else begin r = live[15:8]; m_slo = live[7:0]; end
                m_rs = 1;
            end
            2'd1: begin r = (m_rs != 0) ? m_slo : live[7:0]; m_rs = 0; end
            default: begin r = {7'd0, m_err}; m_err = 0; end
        endcase
        return r;
    endfunction

    function automatic bit exp_write(input logic [1:0] a, input logic [7:0] d);
        bit commit = 0;
        case (a)
            2'd0: m_ext = d;
            2'd1: begin m_low = d; m_pend = 1; end
            2'd2: begin
                if (m_pend) begin m_val = {m_ext, d, m_low}; commit = 1; end
                else m_err = 1;
                m_pend = 0;
            end
            default: ;
        endcase
        return commit;
    endfunction

    // One bus access; called and returning at a falling edge
    task automatic bus_op(input bit w, input logic [1:0] a, input logic [7:0] d);
        logic [23:0] live;
        bit          exp_c;
        live = cnt_live;
        exp_c = 0;
        if (w) exp_c = exp_write(a, d);
        else   m_rdata = exp_read(a, live);
        bus_addr = a; bus_wdata = d; bus_wr = w; bus_rd = !w;
        @(negedge clk);
        bus_wr = 0; bus_rd = 0;
        if (w) begin
            if (exp_c) begin
                check(load_strobe == 1'b1, "R2 strobe", 32'(load_strobe), 1);
                check(load_value == m_val, "R2 R3 value", 32'(load_value), 32'(m_val));
            end else begin
                check(load_strobe == 1'b0, (a == 2'd2) ? "R6 no strobe" : "R4 no strobe", 32'(load_strobe), 0);
                check(load_value == m_val, "R4 R5 hold", 32'(load_value), 32'(m_val));
            end
            check(bus_rdata == m_rdata, "R10 rdata hold", 32'(bus_rdata), 32'(m_rdata));
        end else begin
            check(bus_rdata == m_rdata,
                  (a == 2'd0) ? "R8 ext read" : (a == 2'd2) ? "R7 R8 high read" :
                  (a == 2'd1) ? "R7 R9 low read" : "R6 status read",
                  32'(bus_rdata), 32'(m_rdata));
        end
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin : stim
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // R1: reset state
        check(load_value == 24'd0, "R1 value", 32'(load_value), 0);
        check(load_strobe == 1'b0, "R1 strobe", 32'(load_strobe), 0);
        check(bus_rdata == 8'd0, "R1 rdata", 32'(bus_rdata), 0);
        rst_n = 1;
        @(negedge clk);
        check(load_value == 24'd0 && bus_rdata == 8'd0, "R1 after release", 32'(load_value), 0);
        bus_op(0, 2'd3, 0);                               // R1 error flag clear
        // R3: never-written extension gives 0
        bus_op(1, 2'd1, 8'h34); bus_op(1, 2'd2, 8'h12);
        // R3: sticky extension reused
        bus_op(1, 2'd0, 8'hA5); bus_op(1, 2'd1, 8'h78); bus_op(1, 2'd2, 8'h56);
        bus_op(1, 2'd1, 8'h9A); bus_op(1, 2'd2, 8'hBC);
        // R6: orphan high write, flag readback and clear
        bus_op(1, 2'd2, 8'hEE); bus_op(0, 2'd3, 0); bus_op(0, 2'd3, 0);
        // R6: ext only then high is also orphan
        bus_op(1, 2'd0, 8'h11); bus_op(1, 2'd2, 8'h22); bus_op(0, 2'd3, 0);
        // R4: status write ignored
        bus_op(1, 2'd3, 8'hFF);
        // R8, R7, R9 directed reads with gaps so the counter moves
        bus_op(0, 2'd0, 0); bus_op(1, 2'd3, 0); bus_op(0, 2'd2, 0); bus_op(0, 2'd1, 0);
        bus_op(0, 2'd2, 0); bus_op(1, 2'd3, 0); bus_op(0, 2'd1, 0);
        bus_op(0, 2'd1, 0); bus_op(0, 2'd1, 0);
        // Constrained random sequences
        for (int i = 0; i < 600; i++) begin
            int kind;
            kind = int'($urandom % 6);
            case (kind)
                0: begin bus_op(1, 2'd0, 8'($urandom)); bus_op(1, 2'd1, 8'($urandom)); bus_op(1, 2'd2, 8'($urandom)); end
                1: begin bus_op(1, 2'd1, 8'($urandom)); bus_op(1, 2'd2, 8'($urandom)); end
                2: begin bus_op(0, 2'd0, 0); bus_op(0, 2'd2, 0); bus_op(0, 2'd1, 0); end
                3: begin bus_op(0, 2'd2, 0); bus_op(0, 2'd1, 0); end
                4: bus_op(0, 2'd3, 0);
                default: bus_op($urandom % 2 == 1, 2'($urandom), 8'($urandom));
            endcase
            if ($urandom % 3 == 0) @(negedge clk);
        end
        $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule